// File: doc/BRIEF.md
# Black-Level Feedback Loop Controller

This block closes a digital black-level loop once per video line. While the optical-black window strobe is high it averages a fixed, power-of-two number of ADC samples. When the line strobe arrives it takes the difference between that average and a fixed clamp target. It scales the difference by the loop gain and moves a current-DAC drive code against it. The drive code then stays constant until the next line.

A change of the amplifier gain setting puts the loop into a fast lead-in state. In that state the correction is multiplied by a factor N, which a 2-bit select sets. The loop leaves the fast state only after the error has stayed within a settling band for a number of consecutive lines, which a second 2-bit select sets. The drive code saturates at both ends of its range.

Top module: `blfb_loop`

## Requirements
- R1: After reset `dac_drive` is mid-scale (512 with the default 10-bit width) and the loop is in normal-gain mode.
- R2: A sample is accumulated only on a cycle where `ob_win` is high. Only the first 8 samples (2^AVG_LOG2) of a line count. Later samples in the window, and any sample taken while `ob_win` is low, have no effect.
- R3: On a cycle with `line_stb` high, the drive is updated only if 8 samples were collected. Otherwise `dac_drive` is unchanged. In both cases the accumulator is cleared for the next line.
- R4: The error is err = floor(sum/8) - 64. In normal mode the new drive is drive - floor(err/2). It appears on `dac_drive` in the cycle after `line_stb`, and `dac_drive` changes on no other cycle.
- R5: A one-cycle `gain_chg` pulse puts the loop into fast lead-in mode. In that mode N = 2 << `mult_sel` (00→2, 01→4, 10→8, 11→16).
- R6: In fast mode the new drive is drive - floor(err*N/2).
- R7: In fast mode, each updating line with |err| <= 16 adds one to a settle count, and a line with |err| > 16 resets the count to zero. When the count reaches 1 << `hold_sel` lines (00→1, 01→2, 10→4, 11→8), normal mode resumes. The line that completes the count still uses the fast gain.
- R8: A `gain_chg` pulse during fast mode clears the settle count, so the full hold period starts over.
- R9: The drive result is clamped to the range 0 to 1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ob_win | input | 1 | Optical-black window, high while black samples are present |
| line_stb | input | 1 | One-cycle pulse per line that triggers the update |
| adc_data | input | 10 | ADC sample code |
| gain_chg | input | 1 | One-cycle pulse when the amplifier gain setting changes |
| mult_sel | input | 2 | Select for the fast-mode gain multiplier |
| hold_sel | input | 2 | Select for the number of settled lines before fast mode ends |
| dac_drive | output | 10 | Current-DAC drive code |

## Verification
The hardest thing to observe is the lead-in mode, because the block has no status output for it. The bench infers the mode from the size of each drive step. Each test line uses an error small enough to count as settled but non-zero, so a fast-gain step is visibly larger than a normal-gain step. Interleaved lines with an error above 16 LSB, and a repeated gain-change pulse during the hold countdown, reach the count-restart paths. The expected drive sequence then shows exactly which line returns to normal gain.

// File: rtl/blfb_pkg.sv
package blfb_pkg;
   typedef enum logic {MODE_NORMAL = 1'b0, MODE_FAST = 1'b1} loop_mode_t;

   // settled lines required before leaving lead-in: 1,2,4,8
   function automatic logic [3:0] hold_lines(input logic [1:0] sel);
      return 4'd1 << sel;
   endfunction

   // left shift for the lead-in multiplier: N = 2 << sel
   function automatic logic [2:0] fast_shift(input logic [1:0] sel);
      return {1'b0, sel} + 3'd1;
   endfunction
endpackage

// File: rtl/blfb_obavg.sv
module blfb_obavg #(
   parameter int ADC_W    = 10,
   parameter int AVG_LOG2 = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ob_win,
   input  logic                       line_stb,
   input  logic [ADC_W-1:0]           adc_data,
   output logic                       win_full,
   output logic [ADC_W-1:0]           win_avg,
   output logic [AVG_LOG2:0]          smp_cnt
);
   localparam int NS = 1 << AVG_LOG2;
   localparam int CW = AVG_LOG2 + 1;
   localparam int SW = ADC_W + AVG_LOG2;
   localparam logic [CW-1:0] NS_C = CW'(NS);

   logic [CW-1:0] cnt_q;
   logic [SW-1:0] sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sum_q <= '0;
      end else if (line_stb) begin
         cnt_q <= '0;
         sum_q <= '0;
      end else if (ob_win && (cnt_q != NS_C)) begin
         cnt_q <= cnt_q + CW'(1);
         sum_q <= sum_q + SW'(adc_data);
      end
   end

   assign win_full = (cnt_q == NS_C);
   assign win_avg  = sum_q[SW-1:AVG_LOG2];
   assign smp_cnt  = cnt_q;
endmodule

// File: rtl/blfb_leadin_ctrl.sv
module blfb_leadin_ctrl
   import blfb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       gain_chg,
   input  logic       upd_en,
   input  logic       settled,
   input  logic [1:0] hold_sel,
   output logic       fast
);
   loop_mode_t mode_q;
   logic [3:0] hold_q;
   logic [3:0] hold_nx;

   assign hold_nx = hold_q + 4'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_NORMAL;
         hold_q <= '0;
      end else if (gain_chg) begin
         mode_q <= MODE_FAST;
         hold_q <= '0;
      end else if (upd_en && (mode_q == MODE_FAST)) begin
         if (!settled) begin
            hold_q <= '0;
         end else if (hold_nx >= hold_lines(hold_sel)) begin
            mode_q <= MODE_NORMAL;
            hold_q <= '0;
         end else begin
            hold_q <= hold_nx;
         end
      end
   end

   assign fast = (mode_q == MODE_FAST);
endmodule

// File: rtl/blfb_drive_upd.sv
module blfb_drive_upd
   import blfb_pkg::*;
#(
   parameter int ERR_W         = 11,
   parameter int DRV_W         = 10,
   parameter int GAIN_DIV_LOG2 = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    upd_en,
   input  logic                    fast,
   input  logic [1:0]              mult_sel,
   input  logic signed [ERR_W-1:0] err,
   output logic [DRV_W-1:0]        drive
);
   localparam int SCW = ERR_W + 4;
   localparam int NW  = ((SCW > DRV_W) ? SCW : DRV_W) + 2;
   localparam logic [DRV_W-1:0]     DRV_MID = DRV_W'(1) << (DRV_W - 1);
   localparam logic [DRV_W-1:0]     DRV_MAX = '1;
   localparam logic signed [NW-1:0] LIM_HI  = NW'({1'b0, DRV_MAX});

   logic [2:0]              shamt;
   logic signed [SCW-1:0]   err_ext;
   logic signed [SCW-1:0]   scaled;
   logic signed [SCW-1:0]   step;
   logic signed [NW-1:0]    cur_s;
   logic signed [NW-1:0]    nxt_s;
   logic [DRV_W-1:0]        sat_v;
   logic [DRV_W-1:0]        drive_q;

   assign shamt   = fast ? fast_shift(mult_sel) : 3'd0;
   assign err_ext = SCW'(err);
   assign scaled  = err_ext <<< shamt;

   generate
      if (GAIN_DIV_LOG2 == 0) begin : g_unit_gain
         assign step = scaled;
      end else begin : g_div_gain
         assign step = scaled >>> GAIN_DIV_LOG2;
      end
   endgenerate

   assign cur_s = $signed(NW'({1'b0, drive_q}));
   assign nxt_s = cur_s - NW'(step);

   always_comb begin
      if (nxt_s < 0)
         sat_v = '0;
      else if (nxt_s > LIM_HI)
         sat_v = DRV_MAX;
      else
         sat_v = nxt_s[DRV_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         drive_q <= DRV_MID;
      else if (upd_en)
         drive_q <= sat_v;
   end

   assign drive = drive_q;
endmodule

// File: rtl/blfb_loop.sv
module blfb_loop
   import blfb_pkg::*;
#(
   parameter int ADC_W         = 10,
   parameter int DRV_W         = 10,
   parameter int AVG_LOG2      = 3,
   parameter int CLAMP_CODE    = 64,
   parameter int SETTLE_LSB    = 16,
   parameter int GAIN_DIV_LOG2 = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ob_win,
   input  logic             line_stb,
   input  logic [ADC_W-1:0] adc_data,
   input  logic             gain_chg,
   input  logic [1:0]       mult_sel,
   input  logic [1:0]       hold_sel,
   output logic [DRV_W-1:0] dac_drive
);
   localparam int ERR_W = ADC_W + 1;

   generate
      if (AVG_LOG2 < 1 || AVG_LOG2 > 8) begin : g_bad_avg
         $error("AVG_LOG2 out of range");
      end
      if (CLAMP_CODE < 0 || CLAMP_CODE >= (1 << ADC_W)) begin : g_bad_clamp
         $error("CLAMP_CODE outside ADC range");
      end
      if (DRV_W < 2) begin : g_bad_drv
         $error("DRV_W too small");
      end
      if (GAIN_DIV_LOG2 < 0 || GAIN_DIV_LOG2 > 4) begin : g_bad_div
         $error("GAIN_DIV_LOG2 out of range");
      end
   endgenerate

   localparam logic signed [ERR_W-1:0] CLAMP_S  = ERR_W'(CLAMP_CODE);
   localparam logic [ERR_W-1:0]        SETTLE_U = ERR_W'(SETTLE_LSB);

   logic                    win_full;
   logic [ADC_W-1:0]        win_avg;
   logic [AVG_LOG2:0]       smp_cnt;
   logic                    upd_en;
   logic signed [ERR_W-1:0] err;
   logic [ERR_W-1:0]        err_abs;
   logic                    settled;
   logic                    fast_q;

   blfb_obavg #(.ADC_W(ADC_W), .AVG_LOG2(AVG_LOG2)) u_avg (
      .clk(clk), .rst_n(rst_n), .ob_win(ob_win), .line_stb(line_stb),
      .adc_data(adc_data), .win_full(win_full), .win_avg(win_avg),
      .smp_cnt(smp_cnt)
   );

   assign upd_en  = line_stb & win_full;
   assign err     = $signed({1'b0, win_avg}) - CLAMP_S;
   assign err_abs = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);
   assign settled = (err_abs <= SETTLE_U);

   blfb_leadin_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .gain_chg(gain_chg), .upd_en(upd_en),
      .settled(settled), .hold_sel(hold_sel), .fast(fast_q)
   );

   blfb_drive_upd #(.ERR_W(ERR_W), .DRV_W(DRV_W), .GAIN_DIV_LOG2(GAIN_DIV_LOG2)) u_drv (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .fast(fast_q),
      .mult_sel(mult_sel), .err(err), .drive(dac_drive)
   );
endmodule

// File: rtl/blfb_chk.sv
module blfb_chk #(
   parameter int AVG_LOG2 = 3,
   parameter int DRV_W    = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_stb,
   input logic              gain_chg,
   input logic              upd_en,
   input logic              settled,
   input logic              fast,
   input logic [AVG_LOG2:0] smp_cnt,
   input logic [DRV_W-1:0]  dac_drive
);
   localparam logic [AVG_LOG2:0] NS_C = (AVG_LOG2+1)'(1 << AVG_LOG2);

   assert_drive_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(dac_drive));

   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      smp_cnt <= NS_C);

   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      line_stb |=> (smp_cnt == '0));

   assert_enter_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
      gain_chg |=> fast);

   assert_fast_stay_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fast && upd_en && !settled) |=> fast);

   assert_mode_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!gain_chg && !upd_en) |=> $stable(fast));
endmodule

bind blfb_loop blfb_chk #(.AVG_LOG2(AVG_LOG2), .DRV_W(DRV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .gain_chg(gain_chg),
   .upd_en(upd_en), .settled(settled), .fast(fast_q), .smp_cnt(smp_cnt),
   .dac_drive(dac_drive)
);

// File: tb/tb_blfb_loop.sv
module tb_blfb_loop;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ob_win = 1'b0;
   logic       line_stb = 1'b0;
   logic [9:0] adc_data = '0;
   logic       gain_chg = 1'b0;
   logic [1:0] mult_sel = '0;
   logic [1:0] hold_sel = '0;
   logic [9:0] dac_drive;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   // model state
   int m_drive;
   bit m_fast;
   int m_cnt;

   always #5 clk = ~clk;

   blfb_loop dut (
      .clk(clk), .rst_n(rst_n), .ob_win(ob_win), .line_stb(line_stb),
      .adc_data(adc_data), .gain_chg(gain_chg), .mult_sel(mult_sel),
      .hold_sel(hold_sel), .dac_drive(dac_drive)
   );

   // {gain_chg, mult_sel, hold_sel, adc}
   localparam int NV = 15;
   localparam logic [14:0] VEC [NV] = '{
      {1'b0, 2'd0, 2'd0, 10'd80},
      {1'b0, 2'd0, 2'd0, 10'd40},
      {1'b1, 2'd1, 2'd1, 10'd100},
      {1'b0, 2'd1, 2'd1, 10'd70},
      {1'b0, 2'd1, 2'd1, 10'd90},
      {1'b0, 2'd1, 2'd1, 10'd70},
      {1'b0, 2'd1, 2'd1, 10'd70},
      {1'b0, 2'd1, 2'd1, 10'd70},
      {1'b1, 2'd2, 2'd0, 10'd50},
      {1'b0, 2'd2, 2'd0, 10'd50},
      {1'b1, 2'd0, 2'd2, 10'd64},
      {1'b0, 2'd0, 2'd2, 10'd60},
      {1'b0, 2'd0, 2'd2, 10'd60},
      {1'b0, 2'd0, 2'd2, 10'd60},
      {1'b0, 2'd0, 2'd2, 10'd60}
   };

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic pulse_gc();
      @(negedge clk); gain_chg = 1'b1;
      @(negedge clk); gain_chg = 1'b0;
      m_fast = 1; m_cnt = 0;
   endtask

   // model one valid line per the requirements; returns tag
   function automatic string model_line(input int adc);
      int err, mult, nd;
      string tag;
      err  = adc - 64;
      mult = m_fast ? (2 << mult_sel) : 1;
      nd   = m_drive - ((err * mult) >>> 1);
      tag  = m_fast ? "R6" : "R4";
      if (nd < 0) begin nd = 0; tag = "R9"; end
      if (nd > 1023) begin nd = 1023; tag = "R9"; end
      m_drive = nd;
      if (m_fast) begin
         if (err > 16 || err < -16) m_cnt = 0;
         else begin
            m_cnt++;
            if (m_cnt >= (1 << hold_sel)) begin m_fast = 0; m_cnt = 0; end
         end
      end
      return tag;
   endfunction

   // nsmp samples of v in window, then tail samples of junk in window
   task automatic run_line(input int v, input int nsmp, input int tail);
      for (int i = 0; i < nsmp + tail; i++) begin
         @(negedge clk);
         ob_win = 1'b1;
         adc_data = (i < nsmp) ? 10'(v) : 10'd1023;
      end
      @(negedge clk); ob_win = 1'b0; adc_data = 10'd0;   // out-of-window junk
      @(negedge clk); adc_data = 10'd1000;
      @(negedge clk); line_stb = 1'b1;
      @(negedge clk); line_stb = 1'b0;
   endtask

   task automatic line_and_check(input int v, input string note);
      string tag;
      run_line(v, 8, 0);
      tag = model_line(v);
      check({tag, note}, int'(dac_drive), m_drive);
   endtask

   initial begin
      m_drive = 512; m_fast = 0; m_cnt = 0;
      repeat (3) @(negedge clk);
      check("R1 reset drive", int'(dac_drive), 512);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: normal mode after reset, err=10 gives step 5
      line_and_check(74, " normal after reset R1");

      // vector table
      for (int k = 0; k < NV; k++) begin
         mult_sel = VEC[k][13:12];
         hold_sel = VEC[k][11:10];
         if (VEC[k][14]) pulse_gc();
         line_and_check(int'(VEC[k][9:0]), " table");
      end

      // R3: too few samples -> no update, accumulator cleared
      run_line(200, 5, 0);
      check("R3 partial window", int'(dac_drive), m_drive);
      line_and_check(70, " R3 clear after partial");

      // R2: samples beyond the 8th in the window are ignored
      run_line(72, 8, 4);
      void'(model_line(72));
      check("R2 extra samples", int'(dac_drive), m_drive);

      // R9: saturation low then high under N=16
      mult_sel = 2'd3; hold_sel = 2'd0;
      pulse_gc();
      line_and_check(1023, " R9 low");
      check("R9 floor", int'(dac_drive), 0);
      line_and_check(0, " R9 mid");
      line_and_check(0, " R9 high");
      check("R9 ceiling", int'(dac_drive), 1023);

      // R5/R7/R8: hold of 4 lines, restarted by a second gain change
      mult_sel = 2'd0; hold_sel = 2'd2;
      pulse_gc();
      line_and_check(54, " R5 fast N=2");
      line_and_check(54, " R7 hold");
      line_and_check(54, " R7 hold");
      pulse_gc();
      line_and_check(54, " R8 restart");
      line_and_check(54, " R8 restart");
      line_and_check(54, " R8 restart");
      line_and_check(54, " R8 exit line");
      line_and_check(54, " R7 back to normal");
      check("R7 normal step", m_fast ? 1 : 0, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule